// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block manages sixteen general-purpose I/O lines behind a small memory-mapped register bus with 32-bit word access. Software sets a direction per line, sets the level driven on lines that are outputs, and reads the levels seen on the pins through a pin-enable gate. Every input pin passes through a synchronizer. The block then looks for a transition of a chosen polarity on each line that is configured as an input.

A qualifying transition on an unmasked input line sets a sticky status bit. The single interrupt output is the OR of all status bits and stays high until software clears every set bit with write-one-to-clear accesses. Each line picks rising or falling detection on its own. There is no both-edge mode.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, the registers at offsets 0x04 (output data), 0x08 (direction), 0x0C (polarity), 0x10 (mask) and 0x18 (pin enable) read 0x0000FFFF. Status (0x14) reads 0, the synchronized inputs are 0, `irq` is 0 and `pin_out` is 0.
- R2: A write to 0x04, 0x08, 0x0C, 0x10 or 0x18 stores bits 15:0 of `bus_wdata` and ignores bits 31:16. A later read of the same offset returns the stored value in bits 15:0 and zeros in bits 31:16.
- R3: A read of offset 0x00 returns the synchronized pin levels ANDed bitwise with the pin-enable register.
- R4: `pin_out[i]` equals output-data bit i while direction bit i is 0 (output), and is 0 while direction bit i is 1 (input).
- R5: A polarity bit of 1 selects rising-edge detection and a 0 selects falling-edge detection. A pin level held steady before a clock edge sets its status bit at the third clock edge, so `irq` is high after that edge and not before it.
- R6: An edge sets its status bit only when direction bit = 1 and mask bit = 0 in the cycle the edge is seen. A transition on a masked line or an output line leaves status unchanged.
- R7: A write to 0x14 clears every status bit written as 1 and leaves the other status bits unchanged.
- R8: `irq` is high while any status bit is 1 and low once all status bits are 0.
- R9: When a clear write to 0x14 and a new event on the same line take effect at the same clock edge, the status bit stays 1.
- R10: Writes to 0x00 and to unmapped offsets change no register. Reads of unmapped offsets (0x1C and above, or addresses not word aligned) return 0.
- R11: An access is presented by holding `bus_sel` high for one cycle. `bus_ready` is high in the following cycle, and `bus_rdata` is valid in that same cycle.
- R12: A status bit stays set after its pin returns to the previous level, until software clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data (bits 15:0 used) |
| bus_rdata | output | 32 | Read data, zero-extended |
| bus_ready | output | 1 | Access complete, rdata valid |
| pin_in | input | 16 | Asynchronous input pins |
| pin_out | output | 16 | Output pin levels |
| irq | output | 1 | Level interrupt |

## Verification
Two functions can take effect at the same clock edge: a software write-one-to-clear of a status bit, and a new edge event on that same line. The bench first latches an event on one line. It then raises that pin again so that the event arrives exactly at the edge where a clear of that bit is written: the pin change is placed two cycles before the write's access edge, to match the synchronizer latency. It then reads the status register and expects the bit still set, because the new event takes priority over the clear. A follow-up clear with no event must then bring the bit and `irq` back to zero.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

   // Register index = byte offset / 4; the decode depends on this order.
   typedef enum logic [2:0] {
      REG_DIN  = 3'd0,
      REG_DOUT = 3'd1,
      REG_DIR  = 3'd2,
      REG_POL  = 3'd3,
      REG_MASK = 3'd4,
      REG_STAT = 3'd5,
      REG_PEN  = 3'd6,
      REG_NONE = 3'd7
   } gpio_reg_e;

   localparam int unsigned NUM_MAPPED = 7;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned NUM_LINES   = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] pin_i,
   output logic [NUM_LINES-1:0] level_o,
   output logic [NUM_LINES-1:0] prev_o
);

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: SYNC_STAGES must be at least 2");
   end

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[SYNC_STAGES-2:0], pin_i[g]};
      end
      assign level_o[g] = chain_q[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_o <= '0;
      else        prev_o <= level_o;
   end

endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
   parameter int unsigned NUM_LINES = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] level_i,
   input  logic [NUM_LINES-1:0] prev_i,
   input  logic [NUM_LINES-1:0] pol_i,
   input  logic [NUM_LINES-1:0] armed_i,
   output logic [NUM_LINES-1:0] evt_o
);

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      logic moved;
      assign moved    = level_i[g] ^ prev_i[g];
      // Level after the transition must match the selected polarity.
      assign evt_o[g] = armed_i[g] & moved & (level_i[g] == pol_i[g]);
   end

   // An event is only flagged when the synchronized level differs from the held one.
   assert_evt_needs_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_o & ~(level_i ^ prev_i)) == '0);

endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg #(
   parameter int unsigned NUM_LINES = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] evt_i,
   input  logic [NUM_LINES-1:0] clr_i,
   input  logic [NUM_LINES-1:0] armed_i,
   output logic [NUM_LINES-1:0] status_o,
   output logic                 irq_o
);

   logic [NUM_LINES-1:0] status_q, status_d;

   // New events take priority over a clear in the same cycle.
   always_comb status_d = (status_q & ~clr_i) | evt_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= status_d;
   end

   assign status_o = status_q;
   assign irq_o    = |status_q;

   assert_set_only_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_q & ~$past(status_q) & ~$past(armed_i)) == '0));

   assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_i & ~evt_i)) |=> ((status_q & $past(clr_i & ~evt_i)) == '0));

   assert_event_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_i & evt_i)) |=> ((status_q & $past(clr_i & evt_i)) == $past(clr_i & evt_i)));

   assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(status_q & ~clr_i) & ~status_q) == '0));

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_edge_pkg::*;
#(
   parameter int unsigned NUM_LINES = 16,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic                 bus_ready,
   input  logic [NUM_LINES-1:0] level_i,
   input  logic [NUM_LINES-1:0] status_i,
   output logic [NUM_LINES-1:0] dout_o,
   output logic [NUM_LINES-1:0] dir_o,
   output logic [NUM_LINES-1:0] pol_o,
   output logic [NUM_LINES-1:0] mask_o,
   output logic [NUM_LINES-1:0] pen_o,
   output logic [NUM_LINES-1:0] clr_o
);

   localparam int unsigned IDX_W = ADDR_W - 2;

   if (ADDR_W < 5) begin : g_bad_addr
      $error("gpio_regfile: ADDR_W must reach offset 0x18");
   end
   if (NUM_LINES > DATA_W) begin : g_bad_width
      $error("gpio_regfile: NUM_LINES exceeds DATA_W");
   end

   gpio_reg_e            sel_reg;
   logic                 wr;
   logic [NUM_LINES-1:0] wdat;
   logic [NUM_LINES-1:0] rd_val;
   logic [DATA_W-1:0]    rdata_q;
   logic                 ready_q;

   if (NUM_LINES < DATA_W) begin : g_unused_hi
      logic unused_hi;
      assign unused_hi = ^bus_wdata[DATA_W-1:NUM_LINES];
   end

   always_comb begin
      sel_reg = REG_NONE;
      if (bus_addr[1:0] == 2'b00 &&
          bus_addr[ADDR_W-1:2] < IDX_W'(NUM_MAPPED))
         sel_reg = gpio_reg_e'(bus_addr[4:2]);
   end

   assign wr   = bus_sel & bus_we;
   assign wdat = bus_wdata[NUM_LINES-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_o <= '1;
         dir_o  <= '1;
         pol_o  <= '1;
         mask_o <= '1;
         pen_o  <= '1;
      end else if (wr) begin
         case (sel_reg)
            REG_DOUT: dout_o <= wdat;
            REG_DIR:  dir_o  <= wdat;
            REG_POL:  pol_o  <= wdat;
            REG_MASK: mask_o <= wdat;
            REG_PEN:  pen_o  <= wdat;
            default:  ;
         endcase
      end
   end

   assign clr_o = (wr && sel_reg == REG_STAT) ? wdat : '0;

   always_comb begin
      case (sel_reg)
         REG_DIN:  rd_val = level_i & pen_o;
         REG_DOUT: rd_val = dout_o;
         REG_DIR:  rd_val = dir_o;
         REG_POL:  rd_val = pol_o;
         REG_MASK: rd_val = mask_o;
         REG_STAT: rd_val = status_i;
         REG_PEN:  rd_val = pen_o;
         default:  rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         ready_q <= 1'b0;
      end else begin
         ready_q <= bus_sel;
         if (bus_sel && !bus_we) rdata_q <= DATA_W'(rd_val);
         else                    rdata_q <= '0;
      end
   end

   assign bus_rdata = rdata_q;
   assign bus_ready = ready_q;

   assert_ready_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel |=> bus_ready);

   assert_no_spurious_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |=> !bus_ready);

   assert_unmapped_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && sel_reg == REG_NONE) |=> (bus_rdata == '0));

   assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel_reg == REG_DIR) |=> (dir_o == $past(wdat)));

   assert_rdata_zero_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ready |-> (bus_rdata >> NUM_LINES) == '0);

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl #(
   parameter int unsigned NUM_LINES   = 16,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic                 bus_ready,
   input  logic [NUM_LINES-1:0] pin_in,
   output logic [NUM_LINES-1:0] pin_out,
   output logic                 irq
);

   logic [NUM_LINES-1:0] level, prev, evt, armed;
   logic [NUM_LINES-1:0] dout, dir, pol, mask, pen, clr, status;

   gpio_in_sync #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_in), .level_o(level), .prev_o(prev));

   assign armed = dir & ~mask;

   gpio_edge_det #(.NUM_LINES(NUM_LINES)) u_edge (
      .clk(clk), .rst_n(rst_n), .level_i(level), .prev_i(prev),
      .pol_i(pol), .armed_i(armed), .evt_o(evt));

   gpio_irq_agg #(.NUM_LINES(NUM_LINES)) u_irq (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .clr_i(clr), .armed_i(armed),
      .status_o(status), .irq_o(irq));

   gpio_regfile #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ready(bus_ready), .level_i(level), .status_i(status),
      .dout_o(dout), .dir_o(dir), .pol_o(pol), .mask_o(mask), .pen_o(pen),
      .clr_o(clr));

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_drive
      assign pin_out[g] = dir[g] ? 1'b0 : dout[g];
   end

   assert_inputs_not_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & dir) == '0);

   assert_irq_drop_needs_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(|clr));

   assert_irq_rise_needs_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(|evt));

endmodule

// File: tb/sim_gpio_edge_ctrl.sv
module sim_gpio_edge_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   typedef struct {
      bit          is_rd;
      logic [31:0] exp;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_ready;
   logic [15:0] pins = '0;
   logic [15:0] pin_out;
   logic        irq;

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;
   item_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_edge_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ready(bus_ready), .pin_in(pins), .pin_out(pin_out), .irq(irq));

   // Monitor: every completed access pops one scoreboard entry.
   always @(negedge clk) begin
      if (rst_n && bus_ready) begin
         if (sb_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R11: ready with no pending access, got 1 expected 0");
         end else begin
            item_t it;
            it = sb_q.pop_front();
            if (it.is_rd) begin
               n_cmp++;
               if (bus_rdata !== it.exp) begin
                  n_bad++;
                  $display("FAIL %s: rdata got %h expected %h", it.tag, bus_rdata, it.exp);
               end
            end
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      item_t it;
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      it.is_rd = 1'b0; it.exp = '0; it.tag = "wr";
      sb_q.push_back(it);
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
      item_t it;
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      it.is_rd = 1'b1; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic chk(input logic [31:0] got, input logic [31:0] e, input string tag);
      n_cmp++;
      if (got !== e) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, e);
      end
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk({31'd0, irq}, 0, "R1 irq");
      chk({16'd0, pin_out}, 0, "R1 R4 pin_out");
      rd(8'h04, 32'h0000FFFF, "R1 dout");
      rd(8'h08, 32'h0000FFFF, "R1 dir");
      rd(8'h0C, 32'h0000FFFF, "R1 pol");
      rd(8'h10, 32'h0000FFFF, "R1 mask");
      rd(8'h14, 32'h00000000, "R1 status");
      rd(8'h18, 32'h0000FFFF, "R1 pen");
      rd(8'h00, 32'h00000000, "R1 din");

      // R2 / R4
      wr(8'h04, 32'hDEADA5C3);
      rd(8'h04, 32'h0000A5C3, "R2 dout");
      wr(8'h08, 32'h1234FF00);
      rd(8'h08, 32'h0000FF00, "R2 dir");
      @(negedge clk);
      chk({16'd0, pin_out}, 32'h000000C3, "R4 pin_out");

      // R3 input read through pin enable
      pins = 16'h1234;
      settle();
      wr(8'h18, 32'h00000FF0);
      rd(8'h00, 32'h00000230, "R3 din gated");

      // R10 ignored writes, unmapped reads
      wr(8'h00, 32'h0000FFFF);
      rd(8'h00, 32'h00000230, "R10 din write ignored");
      wr(8'h1C, 32'h00005555);
      rd(8'h1C, 32'h00000000, "R10 unmapped read");
      rd(8'h05, 32'h00000000, "R10 misaligned read");
      rd(8'h04, 32'h0000A5C3, "R10 dout intact");
      rd(8'h10, 32'h0000FFFF, "R10 mask intact");

      // Edge setup: all inputs, lines 0-7 rising, 8-15 falling, unmasked
      wr(8'h08, 32'h0000FFFF);
      wr(8'h0C, 32'h000000FF);
      wr(8'h10, 32'h00000000);
      wr(8'h18, 32'h0000FFFF);
      wr(8'h14, 32'h0000FFFF);
      rd(8'h14, 32'h00000000, "R7 start clear");

      // R5 latency on line 0 rising
      @(negedge clk); pins = 16'h1235;
      @(negedge clk); chk({31'd0, irq}, 0, "R5 irq after 1 edge");
      @(negedge clk); chk({31'd0, irq}, 0, "R5 irq after 2 edges");
      @(negedge clk); chk({31'd0, irq}, 1, "R5 R8 irq after 3 edges");
      rd(8'h14, 32'h00000001, "R5 rising line0");

      // Wrong-polarity transitions: line0 falls, line8 rises -> no new bits
      pins = 16'h1334;
      settle();
      rd(8'h14, 32'h00000001, "R5 R12 wrong polarity / sticky");
      // line9 falls on a falling-polarity line
      pins = 16'h1134;
      settle();
      rd(8'h14, 32'h00000201, "R5 falling line9");

      // R6: mask line2, line3 output
      wr(8'h10, 32'h00000004);
      wr(8'h08, 32'h0000FFF7);
      pins = 16'h1138;
      settle();
      pins = 16'h113C;
      settle();
      rd(8'h14, 32'h00000201, "R6 masked/output lines ignored");

      // R7 / R8
      wr(8'h14, 32'h00000001);
      rd(8'h14, 32'h00000200, "R7 partial clear");
      chk({31'd0, irq}, 1, "R8 irq still high");
      wr(8'h14, 32'h00000200);
      rd(8'h14, 32'h00000000, "R7 full clear");
      chk({31'd0, irq}, 0, "R8 irq low");

      // R9: event and clear at same edge on line4
      wr(8'h10, 32'h00000000);
      wr(8'h08, 32'h0000FFFF);
      pins = 16'h112C;
      settle();
      pins = 16'h113C;
      settle();
      rd(8'h14, 32'h00000010, "R9 line4 set");
      pins = 16'h112C;
      settle();
      @(negedge clk); pins = 16'h113C;
      @(negedge clk);
      wr(8'h14, 32'h00000010);
      rd(8'h14, 32'h00000010, "R9 event wins over clear");
      wr(8'h14, 32'h00000010);
      rd(8'h14, 32'h00000000, "R7 clear after collision");
      chk({31'd0, irq}, 0, "R8 irq low at end");

      repeat (3) @(negedge clk);
      chk(sb_q.size(), 0, "R11 all accesses completed");
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < WATCHDOG) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule